// File: doc/BRIEF.md
# Memory Test Pattern Generator and Checker

This block supplies write data for a memory test and verifies the data that comes back. A 3-bit mode code selects one of six pattern families for a 16-bit data bus:
- address-as-data
- hammer, which toggles every bit on each beat
- neighbor, a single aggressor bit against a quiet background
- walking ones
- walking zeros
- a pseudo-random sequence

The generator side turns a beat index into the word to be written. For the pseudo-random family it instead steps its own sequence register on an advance strobe.

The checker side counts the valid read beats it receives since reset. It rebuilds the expected word for each beat with the same rules and a private copy of the pseudo-random register. On the first mismatch it raises a sticky error flag and stores the number of the failing beat. The mode code is sampled only while reset is held, so a new pattern family always starts from its initial state. Reads are expected to come back in the same order as the writes, starting from beat 0.

Top module: `mem_pattern_engine`

## Requirements
- R1: The mode code on `mode_sel` is captured only in cycles where `rst` is high. Changes to `mode_sel` while `rst` is low have no effect on `wr_data` or on the checker.
- R2: Mode codes 2, 0 and 1 give the address pattern. The word is `wr_index`, zero-extended to 16 bits.
- R3: Mode code 3 gives the hammer pattern. The word is 16'hFFFF for an even index and 16'h0000 for an odd index.
- R4: Mode code 4 gives the neighbor pattern. The aggressor position is (index >> PASS_W) modulo 16, with PASS_W = 4 by default. An even index gives a word with only that bit set, and an odd index gives 16'h0000.
- R5: Mode code 5 gives walking ones. The word has only bit (index modulo 16) set.
- R6: Mode code 6 gives walking zeros. The word is the bitwise complement of the walking-ones word for the same index.
- R7: Mode code 7 gives the pseudo-random pattern, and `wr_index` has no effect on it.
  - After reset `wr_data` is 16'hACE1.
  - Each cycle with `wr_adv` high steps the state one step. The state shifts left one bit, and bit 0 takes the XOR of bits 15, 13, 12 and 10.
- R8: The checker compares each beat with `rd_valid` high against the expected word for read beat k. Here k counts the valid beats since reset, starting at 0. The expected word follows R2 to R6 with index k. In mode 7 it follows the R7 sequence, stepped once per valid beat. A mismatch sets `err_flag` at the next clock edge.
- R9: `err_flag` stays high until reset. `rd_data` is ignored in cycles where `rd_valid` is low.
- R10: `err_index` holds k of the first failing beat. Later failures do not change it.
- R11: While reset is applied, and after it, `err_flag` is 0 and `err_index` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; mode is captured while high |
| mode_sel | input | 3 | Pattern family code |
| wr_index | input | IDX_W | Beat index for the write pattern |
| wr_adv | input | 1 | Steps the write-side pseudo-random state |
| wr_data | output | 16 | Generated write word |
| rd_valid | input | 1 | Read beat strobe |
| rd_data | input | 16 | Returned read word |
| err_flag | output | 1 | Sticky mismatch flag |
| err_index | output | IDX_W | Read beat number of the first mismatch |

## Verification
The bench checks the index arithmetic at the edges of each family:
- Walking ones at index 15 and 16, where a wrong modulo shows as a stuck or missing bit.
- Neighbor pass boundaries, where a design that moved the aggressor every beat, or never, returns the wrong bit.
- The reserved codes, which a wrong decode would turn into zeros.

It also checks that a mode change outside reset is ignored. A design that took `mode_sel` directly would switch patterns partway through a run. On the checker side, a second mismatch must not move the recorded beat number, and garbage arriving with `rd_valid` low must not set the flag. The pseudo-random sequences are compared step by step on both sides, so a wrong tap or seed fails at once.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

    localparam int DATA_W = 16;
    localparam int POS_W  = $clog2(DATA_W);

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [2:0] {
        PM_RSV0   = 3'd0,
        PM_RSV1   = 3'd1,
        PM_ADDR   = 3'd2,
        PM_HAMMER = 3'd3,
        PM_NEIGH  = 3'd4,
        PM_WALK1  = 3'd5,
        PM_WALK0  = 3'd6,
        PM_PRBS   = 3'd7
    } pat_mode_e;

    localparam word_t PRBS_SEED = 16'hACE1;

    // One step of the 16-bit maximal-length shift register (taps 16,14,13,11).
    function automatic word_t prbs_step(input word_t s);
        return {s[DATA_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic word_t bit_at(input logic [POS_W-1:0] pos);
        return word_t'(1) << pos;
    endfunction

endpackage

// File: rtl/mpg_lfsr.sv
module mpg_lfsr
    import mpg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    output word_t state
);
    word_t state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= PRBS_SEED;
        else if (adv)
            state_q <= prbs_step(state_q);
    end

    assign state = state_q;
endmodule

// File: rtl/mpg_expect.sv
module mpg_expect
    import mpg_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int PASS_W = 4
) (
    input  pat_mode_e        mode,
    input  logic [IDX_W-1:0] idx,
    input  word_t            prbs_state,
    output word_t            word
);
    logic [POS_W-1:0] walk_pos;
    logic [POS_W-1:0] neigh_pos;
    word_t            walk_word;

    assign walk_pos  = idx[POS_W-1:0];
    assign neigh_pos = POS_W'(idx >> PASS_W);
    assign walk_word = bit_at(walk_pos);

    always_comb begin
        unique case (mode)
            PM_HAMMER: word = idx[0] ? '0 : '1;
            PM_NEIGH:  word = idx[0] ? '0 : bit_at(neigh_pos);
            PM_WALK1:  word = walk_word;
            PM_WALK0:  word = ~walk_word;
            PM_PRBS:   word = prbs_state;
            default:   word = DATA_W'(idx);   // address, and the reserved codes
        endcase
    end
endmodule

// File: rtl/mpg_checker.sv
module mpg_checker
    import mpg_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int PASS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  pat_mode_e        mode,
    input  logic             rd_valid,
    input  word_t            rd_data,
    output word_t            rd_expect,
    output logic             err_flag,
    output logic [IDX_W-1:0] err_index
);
    logic [IDX_W-1:0] beat_q;
    word_t            prbs_state;
    logic [DATA_W-1:0] bit_diff;
    logic             mismatch;
    logic             err_q;
    logic [IDX_W-1:0] err_idx_q;

    mpg_lfsr u_rd_lfsr (
        .clk   (clk),
        .rst   (rst),
        .adv   (rd_valid),
        .state (prbs_state)
    );

    mpg_expect #(.IDX_W(IDX_W), .PASS_W(PASS_W)) u_rd_expect (
        .mode       (mode),
        .idx        (beat_q),
        .prbs_state (prbs_state),
        .word       (rd_expect)
    );

    for (genvar b = 0; b < DATA_W; b++) begin : g_cmp
        assign bit_diff[b] = rd_data[b] ^ rd_expect[b];
    end

    assign mismatch = rd_valid && (|bit_diff);

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q    <= '0;
            err_q     <= 1'b0;
            err_idx_q <= '0;
        end else begin
            if (rd_valid)
                beat_q <= beat_q + 1'b1;
            if (mismatch && !err_q) begin
                err_q     <= 1'b1;
                err_idx_q <= beat_q;
            end
        end
    end

    assign err_flag  = err_q;
    assign err_index = err_idx_q;
endmodule

// File: rtl/mem_pattern_engine.sv
module mem_pattern_engine
    import mpg_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int PASS_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_sel,
    input  logic [IDX_W-1:0] wr_index,
    input  logic             wr_adv,
    output logic [15:0]      wr_data,
    input  logic             rd_valid,
    input  logic [15:0]      rd_data,
    output logic             err_flag,
    output logic [IDX_W-1:0] err_index
);
    pat_mode_e mode_q;
    word_t     wr_prbs;
    word_t     rd_expect;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= pat_mode_e'(mode_sel);
    end

    mpg_lfsr u_wr_lfsr (
        .clk   (clk),
        .rst   (rst),
        .adv   (wr_adv),
        .state (wr_prbs)
    );

    mpg_expect #(.IDX_W(IDX_W), .PASS_W(PASS_W)) u_wr_expect (
        .mode       (mode_q),
        .idx        (wr_index),
        .prbs_state (wr_prbs),
        .word       (wr_data)
    );

    mpg_checker #(.IDX_W(IDX_W), .PASS_W(PASS_W)) u_checker (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_q),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_expect (rd_expect),
        .err_flag  (err_flag),
        .err_index (err_index)
    );
endmodule

// File: rtl/mpg_sva.sv
module mpg_sva
    import mpg_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst,
    input pat_mode_e        mode_q,
    input logic [15:0]      wr_data,
    input logic             rd_valid,
    input logic [15:0]      rd_data,
    input logic [15:0]      rd_expect,
    input logic             err_flag,
    input logic [IDX_W-1:0] err_index
);
    // R1: captured mode holds while reset is low
    a_r1_mode_held: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q));

    // R3: hammer words are all ones or all zeros
    a_r3_hammer_full: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_HAMMER) |-> (wr_data == 16'hFFFF || wr_data == 16'h0000));

    // R5: walking ones has exactly one bit set
    a_r5_walk1_single: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_WALK1) |-> ($countones(wr_data) == 1));

    // R6: walking zeros has exactly one bit clear
    a_r6_walk0_single: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_WALK0) |-> ($countones(wr_data) == 15));

    // R8: a valid mismatching beat raises the flag next cycle
    a_r8_mismatch_flags: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_data != rd_expect) |=> err_flag);

    // R9: flag is sticky and only rises after a valid beat
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);
    a_r9_rise_on_valid: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(rd_valid));

    // R10: recorded index is frozen once the flag is up
    a_r10_index_frozen: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> $stable(err_index));

    // R11: reset clears the error state
    a_r11_reset_clear: assert property (@(posedge clk)
        rst |=> (!err_flag && err_index == '0));
endmodule

bind mem_pattern_engine mpg_sva #(.IDX_W(IDX_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_expect (rd_expect),
    .err_flag  (err_flag),
    .err_index (err_index)
);

// File: tb/tb_mem_pattern_engine.sv
module tb_mem_pattern_engine;
    localparam int IDX_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       mode_sel = 3'd2;
    logic [IDX_W-1:0] wr_index = '0;
    logic             wr_adv = 1'b0;
    logic [15:0]      wr_data;
    logic             rd_valid = 1'b0;
    logic [15:0]      rd_data = '0;
    logic             err_flag;
    logic [IDX_W-1:0] err_index;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    mem_pattern_engine #(.IDX_W(IDX_W), .PASS_W(4)) dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .wr_index(wr_index),
        .wr_adv(wr_adv), .wr_data(wr_data), .rd_valid(rd_valid),
        .rd_data(rd_data), .err_flag(err_flag), .err_index(err_index)
    );

    typedef struct packed {
        logic [2:0]       mode;
        logic [IDX_W-1:0] idx;
        logic [15:0]      exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{3'd2, 10'h05A, 16'h005A},   // R2
        '{3'd2, 10'h3FF, 16'h03FF},   // R2
        '{3'd0, 10'h123, 16'h0123},   // R2 reserved
        '{3'd1, 10'h001, 16'h0001},   // R2 reserved
        '{3'd3, 10'h000, 16'hFFFF},   // R3
        '{3'd3, 10'h007, 16'h0000},   // R3
        '{3'd3, 10'h02A, 16'hFFFF},   // R3
        '{3'd4, 10'h000, 16'h0001},   // R4
        '{3'd4, 10'h001, 16'h0000},   // R4
        '{3'd4, 10'h030, 16'h0008},   // R4
        '{3'd4, 10'h0F2, 16'h8000},   // R4
        '{3'd4, 10'h100, 16'h0001},   // R4 wrap of aggressor
        '{3'd5, 10'h000, 16'h0001},   // R5
        '{3'd5, 10'h00F, 16'h8000},   // R5
        '{3'd5, 10'h010, 16'h0001},   // R5 wrap
        '{3'd5, 10'h023, 16'h0008},   // R5
        '{3'd6, 10'h000, 16'hFFFE},   // R6
        '{3'd6, 10'h01F, 16'h7FFF}    // R6
    };

    function automatic logic [15:0] tb_prbs(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [15:0] tb_word(input logic [2:0] m, input logic [IDX_W-1:0] k,
                                            input logic [15:0] p);
        case (m)
            3'd3: return k[0] ? 16'h0000 : 16'hFFFF;
            3'd4: return k[0] ? 16'h0000 : (16'h1 << ((k >> 4) % 16));
            3'd5: return 16'h1 << (k % 16);
            3'd6: return ~(16'h1 << (k % 16));
            3'd7: return p;
            default: return 16'(k);
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        mode_sel = m;
        rst = 1'b1;
        rd_valid = 1'b0;
        wr_adv = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic rd_beat(input logic [15:0] d);
        rd_valid = 1'b1;
        rd_data  = d;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] p;
        logic [2:0]  cur;

        // R11: state during reset and just after it
        @(negedge clk);
        @(negedge clk);
        check("R11 err_flag in reset", 32'(err_flag), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 err_flag", 32'(err_flag), 0);
        check("R11 err_index", 32'(err_index), 0);

        // Vector table walk
        cur = 3'bxxx;
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].mode !== cur) begin
                do_reset(VECS[i].mode);
                cur = VECS[i].mode;
            end
            wr_index = VECS[i].idx;
            #1;
            check($sformatf("R2-6 vec%0d", i), 32'(wr_data), 32'(VECS[i].exp));
        end

        // R1: a mode change without reset is ignored
        do_reset(3'd5);
        mode_sel = 3'd3;
        wr_index = 10'd2;
        @(negedge clk);
        @(negedge clk);
        check("R1 mode held", 32'(wr_data), 32'h0004);
        do_reset(3'd3);
        @(negedge clk);
        check("R1 mode after reset", 32'(wr_data), 32'hFFFF);

        // R7: write-side pseudo-random sequence, index ignored
        do_reset(3'd7);
        wr_index = 10'h155;
        #1;
        check("R7 seed", 32'(wr_data), 32'hACE1);
        p = 16'hACE1;
        for (int s = 0; s < 24; s++) begin
            wr_adv = 1'b1;
            wr_index = 10'(s * 37);
            @(negedge clk);
            p = tb_prbs(p);
            #1;
            check($sformatf("R7 step%0d", s), 32'(wr_data), 32'(p));
        end
        wr_adv = 1'b0;
        @(negedge clk);
        check("R7 hold without adv", 32'(wr_data), 32'(p));

        // R8: clean passes through the checker for every family
        for (int m = 2; m < 8; m++) begin
            do_reset(3'(m));
            p = 16'hACE1;
            for (int k = 0; k < 40; k++) begin
                rd_beat(tb_word(3'(m), 10'(k), p));
                p = tb_prbs(p);
            end
            check($sformatf("R8 clean mode%0d", m), 32'(err_flag), 0);
        end

        // R8/R10: first failure in address mode at beat 8
        do_reset(3'd2);
        for (int k = 0; k < 8; k++) rd_beat(16'(k));
        check("R8 no error before bad beat", 32'(err_flag), 0);
        rd_beat(16'hBEEF);
        check("R8 flag after mismatch", 32'(err_flag), 1);
        check("R10 first index", 32'(err_index), 8);
        rd_beat(16'h1234);
        rd_beat(16'd10);
        check("R9 flag sticky", 32'(err_flag), 1);
        check("R10 index kept", 32'(err_index), 8);

        // R11: reset clears, R9: rd_data ignored while rd_valid low
        do_reset(3'd2);
        check("R11 flag cleared", 32'(err_flag), 0);
        check("R11 index cleared", 32'(err_index), 0);
        rd_data = 16'hDEAD;
        repeat (5) @(negedge clk);
        check("R9 invalid ignored", 32'(err_flag), 0);
        rd_beat(16'd0);
        rd_beat(16'd1);
        check("R9 count not moved by idle", 32'(err_flag), 0);

        // R8: hammer failure at beat 3
        do_reset(3'd3);
        rd_beat(16'hFFFF);
        rd_beat(16'h0000);
        rd_beat(16'hFFFF);
        rd_beat(16'hFFFF);
        check("R8 hammer flag", 32'(err_flag), 1);
        check("R10 hammer index", 32'(err_index), 3);

        // R8: pseudo-random failure at beat 5
        do_reset(3'd7);
        p = 16'hACE1;
        for (int k = 0; k < 5; k++) begin
            rd_beat(p);
            p = tb_prbs(p);
        end
        rd_beat(~p);
        check("R8 prbs flag", 32'(err_flag), 1);
        check("R10 prbs index", 32'(err_index), 5);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule